// File: doc/BRIEF.md
# Page Shadow Check-Handler Resolver

This block turns an indirect-call target address into a verdict on how the call should be checked. It keeps a small table of 16-bit shadow entries, one for each 4 KiB page inside a configurable address window. The page index is taken from the address bits directly above the page offset. A lookup classifies the page in one of three ways. A page can be invalid, which means the call is a violation. It can be unchecked, which means the page is trusted and the call goes ahead. Or it can be checked, in which case the block also returns the address of the page-aligned handler routine that validates the call.

For a checked page with shadow value V, the handler lies V+1 pages below the page boundary at or above the target. In other words, the target address is rounded up to a multiple of 4096, and then (V+1)×4096 is subtracted. The table is loaded through a single-cycle write port. Lookups arrive on a valid/ready request channel. Results leave on a valid/ready response channel that has one register stage.

Top module: `shadow_resolver`

## Requirements
- R1: After reset, every shadow entry reads as 0 and `rsp_valid_o` is low. An entry written before a reset looks up as invalid after the reset.
- R2: A lookup uses the entry indexed by address bits [PAGE_BITS+IDX_W-1:PAGE_BITS], which are bits [19:12] by default.
- R3: An entry of 16'hFFFF returns kind 1 (unchecked) with handler address 0.
- R4: An entry of 0 returns kind 0 (invalid) with handler address 0.
- R5: Any other entry V returns kind 2 (checked). The handler is the address rounded up to a multiple of 4096, minus (V+1)×4096, taken modulo 2^ADDR_W.
- R6: A target that is already 4096-aligned is not moved by the rounding step.
- R7: An address with any bit at or above PAGE_BITS+IDX_W set returns kind 0, whatever the table holds at the aliased index.
- R8: A write is seen by a lookup accepted on the next cycle. A lookup accepted in the same cycle as the write still sees the old entry.
- R9: A response appears on the cycle after the request is accepted. It holds stable while `rsp_ready_i` is low, and during that time `req_ready_o` is low.
- R10: The handler address always has its low PAGE_BITS bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Shadow table write strobe |
| wr_idx_i | input | IDX_W | Page index to write |
| wr_data_i | input | 16 | Shadow value to write |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request accepted |
| req_addr_i | input | ADDR_W | Call target address |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result consumed |
| rsp_kind_o | output | 2 | 0 invalid, 1 unchecked, 2 checked |
| rsp_handler_o | output | ADDR_W | Handler address, 0 unless checked |

## Verification
The kind and the handler are registered once, at the edge that accepts the request. Both are therefore due one edge after acceptance. The bench drives inputs on the falling edge and samples on the next falling edge, which sits exactly one register away. A table write is launched on one falling edge and a lookup on the following one, so the write lands one edge before the lookup is accepted. The same-edge case puts the write and the lookup on the same falling edge. Under backpressure the bench samples over several falling edges while `rsp_ready_i` is low, then samples again on the edge after it is raised.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int unsigned SHADOW_W = 16;
  localparam logic [SHADOW_W-1:0] CODE_INVALID   = '0;
  localparam logic [SHADOW_W-1:0] CODE_UNCHECKED = '1;

  typedef enum logic [1:0] {
    KIND_INVALID   = 2'd0,
    KIND_UNCHECKED = 2'd1,
    KIND_CHECKED   = 2'd2
  } page_kind_e;
endpackage

// File: rtl/shadow_table.sv
module shadow_table
  import shadow_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [SHADOW_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [SHADOW_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [SHADOW_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CODE_INVALID;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i)); // R8
endmodule

// File: rtl/shadow_decode.sv
module shadow_decode
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned IDX_W     = 8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [SHADOW_W-1:0] entry_i,
  output page_kind_e          kind_o,
  output logic [ADDR_W-1:0]   handler_o
);
  localparam int unsigned PG_W  = ADDR_W - PAGE_BITS;
  localparam int unsigned WIN_W = PAGE_BITS + IDX_W;

  logic            in_window;
  logic [PG_W-1:0] page_up;
  logic [PG_W-1:0] handler_pg;

  generate
    if (WIN_W < ADDR_W) begin : g_window
      assign in_window = (addr_i[ADDR_W-1:WIN_W] == '0);
    end else begin : g_full
      assign in_window = 1'b1;
    end
  endgenerate

  // round up to the page boundary, then step back V+1 pages
  assign page_up    = addr_i[ADDR_W-1:PAGE_BITS] + PG_W'(|addr_i[PAGE_BITS-1:0]);
  assign handler_pg = page_up - (PG_W'(entry_i) + PG_W'(1));

  always_comb begin
    kind_o    = KIND_INVALID;
    handler_o = '0;
    if (in_window) begin
      if (entry_i == CODE_UNCHECKED) begin
        kind_o = KIND_UNCHECKED;
      end else if (entry_i != CODE_INVALID) begin
        kind_o    = KIND_CHECKED;
        handler_o = {handler_pg, {PAGE_BITS{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/shadow_resolver.sv
module shadow_resolver
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned IDX_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [15:0]       wr_data_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [1:0]        rsp_kind_o,
  output logic [ADDR_W-1:0] rsp_handler_o
);
  localparam int unsigned WIN_W = PAGE_BITS + IDX_W;

  logic [SHADOW_W-1:0] entry;
  page_kind_e          kind_d;
  logic [ADDR_W-1:0]   handler_d;
  logic                req_fire;
  logic                rsp_valid_q;
  page_kind_e          kind_q;
  logic [ADDR_W-1:0]   handler_q;

  shadow_table #(.IDX_W(IDX_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .rd_idx_i  (req_addr_i[PAGE_BITS +: IDX_W]),
    .rd_data_o (entry)
  );

  shadow_decode #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) u_decode (
    .addr_i    (req_addr_i),
    .entry_i   (entry),
    .kind_o    (kind_d),
    .handler_o (handler_d)
  );

  assign req_ready_o = !rsp_valid_q || rsp_ready_i;
  assign req_fire    = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      kind_q      <= KIND_INVALID;
      handler_q   <= '0;
    end else if (req_fire) begin
      rsp_valid_q <= 1'b1;
      kind_q      <= kind_d;
      handler_q   <= handler_d;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_kind_o    = kind_q;
  assign rsp_handler_o = handler_q;

  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_kind_o) && $stable(rsp_handler_o)); // R9
  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |-> !req_ready_o); // R9
  AST_RSP_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fire |=> rsp_valid_o); // R9
  AST_HANDLER_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_handler_o[PAGE_BITS-1:0] == '0); // R10
  AST_PLAIN_NO_HANDLER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_kind_o != KIND_CHECKED |-> rsp_handler_o == '0); // R3
  AST_OUTSIDE_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fire && (req_addr_i >> WIN_W) != '0 |=> rsp_kind_o == KIND_INVALID); // R7
endmodule

// File: tb/shadow_resolver_bench.sv
module shadow_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_kind;
  logic [31:0] rsp_handler;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shadow_resolver u_shadow_resolver (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_kind_o(rsp_kind),
    .rsp_handler_o(rsp_handler)
  );

  function automatic logic [31:0] exp_handler(logic [31:0] a, logic [15:0] v);
    logic [31:0] up;
    up = (a + 32'hFFF) & 32'hFFFF_F000;
    return up - ((32'(v) + 32'd1) << 12);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_entry(logic [7:0] idx, logic [15:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(string tag, logic [31:0] a, logic [1:0] ek, logic [31:0] eh);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " kind"}, 32'(rsp_kind), 32'(ek));
    chk({tag, " handler"}, rsp_handler, eh);
  endtask

  task automatic t_reset_state;
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R9 req_ready idle", 32'(req_ready), 32'd1);
    lookup("R1 fresh entry", 32'h0000_5010, 2'd0, 32'h0);
  endtask

  task automatic t_unchecked;
    write_entry(8'h03, 16'hFFFF);
    lookup("R3 R2 unchecked page", 32'h0000_3123, 2'd1, 32'h0);
  endtask

  task automatic t_invalid;
    write_entry(8'h08, 16'h0004);
    write_entry(8'h08, 16'h0000);
    lookup("R4 zero entry", 32'h0000_8ABC, 2'd0, 32'h0);
  endtask

  task automatic t_checked;
    write_entry(8'h20, 16'h0002);
    lookup("R5 mid page", 32'h0002_0010, 2'd2, exp_handler(32'h0002_0010, 16'h2));
    lookup("R5 last byte", 32'h0002_0FFF, 2'd2, 32'h0001_E000);
    lookup("R6 aligned", 32'h0002_0000, 2'd2, 32'h0001_D000);
    write_entry(8'hFF, 16'h0001);
    lookup("R5 top of window", 32'h000F_FFFF, 2'd2, 32'h000F_E000);
    write_entry(8'h01, 16'hFFFE);
    lookup("R5 wraparound", 32'h0000_1001, 2'd2, exp_handler(32'h0000_1001, 16'hFFFE));
  endtask

  task automatic t_window;
    lookup("R7 alias outside window", 32'h0010_3000, 2'd0, 32'h0);
    lookup("R7 high bit outside", 32'h8000_3000, 2'd0, 32'h0);
  endtask

  task automatic t_write_order;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 8'h09; wr_data = 16'h0005;
    req_valid = 1'b1; req_addr = 32'h0000_9000;
    @(negedge clk);
    wr_en = 1'b0;
    req_valid = 1'b0;
    chk("R8 same-cycle old kind", 32'(rsp_kind), 32'd0);
    lookup("R8 next-cycle new entry", 32'h0000_9000, 2'd2, 32'h0000_3000);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h0002_0010;
    @(negedge clk);
    req_addr = 32'h0000_3000;
    chk("R9 rsp after one cycle", 32'(rsp_valid), 32'd1);
    chk("R9 ready low while stalled", 32'(req_ready), 32'd0);
    repeat (2) @(negedge clk);
    chk("R9 held valid", 32'(rsp_valid), 32'd1);
    chk("R9 held kind", 32'(rsp_kind), 32'd2);
    chk("R9 held handler", rsp_handler, 32'h0001_E000);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 next rsp kind", 32'(rsp_kind), 32'd1);
    chk("R10 handler aligned", rsp_handler & 32'hFFF, 32'h0);
    @(negedge clk);
    chk("R9 drains", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset_clears;
    write_entry(8'h05, 16'h0010);
    lookup("R1 before reset", 32'h0000_5000, 2'd2, exp_handler(32'h0000_5000, 16'h10));
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lookup("R1 cleared by reset", 32'h0000_5000, 2'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_unchecked();
    t_invalid();
    t_checked();
    t_window();
    t_write_order();
    t_backpressure();
    t_reset_clears();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule